// File: doc/BRIEF.md
# Many-Time-Programmable Byte Memory Model

This block is a clock-synchronous, synthesizable model of a byte-wide nonvolatile memory that is reprogrammed only by external equipment. Its array is small (256 bytes by default). Each clock edge samples three active-low strobes: chip enable `ce_n`, output enable `oe_n` and write strobe `we_n`. It also samples two flags, `oe_hv` and `a9_hv`, which stand in for a high-voltage level on the output-enable line and on address bit 9. From these inputs it picks one operating mode. The modes are standby, read, output-off, whole-array erase, byte program, inhibit and identification.

Writing follows the rules of such a cell. A program pulse can only clear bits. Only a whole-array erase brings bits back to 1. Both operations are entered through the high-voltage flags and not through command sequences. Each one lasts as long as the low pulse on `we_n`. A pulse shorter than the minimum width, or a mode that changes in the middle of a pulse, leaves the array as it was and raises an error flag.

All analog timings are turned into clock counts from a clock frequency parameter. These cover access from address or chip enable, access from output enable, output turn-off delay and the minimum pulse widths. The interface is a plain pin interface sampled every cycle: it has no valid/ready handshake and applies no back-pressure.

Top module: `mtp_byte_mem`

## Requirements
- R1: After reset the bus is not driven (`dout_en` = 0), `busy` and `err` are 0, and every byte reads FFh.
- R2: With `ce_n`=0, `oe_n`=0, `we_n`=1 and both flags low, the byte at `addr` is driven. This happens once `ce_n` has been low with `addr` equal to its value at the preceding edge for ACC_CYC consecutive edges, and `oe_n` has been low for OE_CYC consecutive edges.
- R3: Once the read condition goes away, the bus stays driven with the last byte for HZ_CYC more edges and then goes undriven.
- R4: While `ce_n`=1 the bus is not driven, and falling edges of `we_n` start nothing: `busy` stays 0 and the array keeps its contents.
- R5: With `ce_n`=0 and no flag high, the bus is not driven when `oe_n`=1 (output-off), or when `oe_n`=0 and `we_n`=0 (inhibit). A `we_n` fall in these modes starts nothing.
- R6: With `ce_n`=0, `oe_hv`=1 and `a9_hv`=0, a falling `we_n` raises `busy`. When `we_n` is sampled high again after at least PROG_CYC edges sampled low, the latched byte becomes old AND `din` and `busy` drops at that edge.
- R7: With `ce_n`=0 and both flags high, a `we_n` low pulse of at least ERASE_CYC sampled edges sets every byte to FFh.
- R8: A pulse shorter than the minimum for its operation sets `err` when `busy` drops and leaves the array unchanged.
- R9: If the mode changes while `busy` is high, the operation ends at once with `err` = 1 and the array unchanged. Such a change is `ce_n` rising, `oe_hv` falling, or `a9_hv` flipping.
- R10: With `a9_hv`=1, `ce_n`=0, `oe_n`=0, `we_n`=1 and `oe_hv`=0, the block drives BFh when `addr`=0 and drives the device code (C5h, C6h, C2h for DEV_SEL 0, 1, 2) when `addr`=1. When any address bit above bit 0 is set, the bus is not driven.
- R11: While `busy` is high the bus is not driven, even inside a turn-off hold window.
- R12: `err` keeps its value until the next program or erase pulse starts, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write/erase strobe, active low |
| oe_hv | input | 1 | Output-enable line held at high voltage |
| a9_hv | input | 1 | Address bit 9 held at high voltage |
| addr | input | AW | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Data driven on the bus |
| dout_en | output | 1 | Bus driver enable; 0 means high impedance |
| busy | output | 1 | Program or erase pulse in progress |
| err | output | 1 | Last pulse was too short or was aborted |

## Verification
The bench builds the block with a 50 MHz clock, a program minimum of 400 ns (20 cycles) and an erase minimum of 2 µs (100 cycles). It selects device code C2h. With these values a full erase, pulses just below and above each minimum, and the aborts fit in a few hundred cycles. The access parameters come out to 4, 2 and 2 cycles. That makes the read latency after an address change and the turn-off window short enough to check edge by edge against the bench's reference model.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_READ,
    MD_OUTOFF,
    MD_ERASE,
    MD_PROG,
    MD_INHIBIT,
    MD_IDENT
  } mtp_mode_t;

  localparam logic [7:0] MFR_CODE = 8'hBF;

  function automatic logic [7:0] dev_code(input int sel);
    case (sel)
      1:       return 8'hC6;
      2:       return 8'hC2;
      default: return 8'hC5;
    endcase
  endfunction

  // round a time in ns up to whole clock cycles, at least one
  function automatic int ns_to_cyc(input longint t_ns, input longint mhz);
    longint c;
    c = (t_ns * mhz + 64'd999) / 64'd1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/mtp_mode_dec.sv
module mtp_mode_dec
  import mtp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      oe_hv,
  input  logic      a9_hv,
  output mtp_mode_t mode
);

  always_comb begin
    if (ce_n)               mode = MD_STANDBY;
    else if (oe_hv && a9_hv) mode = MD_ERASE;
    else if (oe_hv)          mode = MD_PROG;
    else if (oe_n)           mode = MD_OUTOFF;
    else if (!we_n)          mode = MD_INHIBIT;
    else if (a9_hv)          mode = MD_IDENT;
    else                     mode = MD_READ;
  end

endmodule

// File: rtl/mtp_array.sv
module mtp_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic          erase_we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] old_byte;

  assign rdata    = mem[raddr];
  assign old_byte = mem[waddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_we) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_we) begin
      mem[waddr] <= old_byte & wdata;
    end
  end

  // R6
  prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((mem[$past(waddr)] & ~$past(old_byte)) == 8'h00));

  // R7
  erase_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/mtp_pulse_ctl.sv
module mtp_pulse_ctl
  import mtp_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PROG_CYC  = 750,
  parameter int ERASE_CYC = 5000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mtp_mode_t     mode,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          busy,
  output logic          err,
  output logic          prog_we,
  output logic          erase_we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata
);

  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int PW   = $clog2(MAXC + 2);
  localparam logic [PW-1:0] CSAT = PW'(MAXC);

  logic          busy_q, err_q, we_q, kind_q;
  logic [PW-1:0] cnt_q, need;
  logic          mode_ok, fall, start, long_enough;

  assign fall        = we_q & ~we_n;
  assign start       = !busy_q && fall && (mode == MD_ERASE || mode == MD_PROG);
  assign mode_ok     = kind_q ? (mode == MD_ERASE) : (mode == MD_PROG);
  assign need        = kind_q ? PW'(ERASE_CYC) : PW'(PROG_CYC);
  assign long_enough = cnt_q >= need;

  assign prog_we  = busy_q && mode_ok && we_n && !kind_q && long_enough;
  assign erase_we = busy_q && mode_ok && we_n &&  kind_q && long_enough;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      we_q   <= 1'b1;
      kind_q <= 1'b0;
      cnt_q  <= '0;
      waddr  <= '0;
      wdata  <= '0;
    end else begin
      we_q <= we_n;
      if (busy_q) begin
        if (!mode_ok) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end else if (we_n) begin
          busy_q <= 1'b0;
          err_q  <= !long_enough;
        end else if (cnt_q != CSAT) begin
          cnt_q <= cnt_q + PW'(1);
        end
      end else if (start) begin
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        kind_q <= (mode == MD_ERASE);
        cnt_q  <= PW'(1);
        waddr  <= addr;
        wdata  <= din;
      end
    end
  end

  assign busy = busy_q;
  assign err  = err_q;

  // R6
  busy_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(we_n) == 1'b0));

  // R8
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $fell(busy_q));

  // R4
  standby_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !$rose(busy_q));

endmodule

// File: rtl/mtp_read_path.sv
module mtp_read_path
  import mtp_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         ACC_CYC  = 4,
  parameter int         OE_CYC   = 2,
  parameter int         HZ_CYC   = 2,
  parameter logic [7:0] DEV_CODE = 8'hC5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mtp_mode_t     mode,
  input  logic          busy,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          oe_hv,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    arr_rdata,
  output logic [7:0]    dout,
  output logic          dout_en
);

  localparam int CW = 8;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] ce_cnt_q, oe_cnt_q, ce_cnt_d, oe_cnt_d, hold_q;
  logic [AW-1:0] addr_q;
  logic          en_q, id_ok, src_ok, on_d;
  logic [7:0]    val_d, dout_q;

  always_comb begin
    ce_cnt_d = (ce_n || addr != addr_q) ? '0
             : ((ce_cnt_q == CMAX) ? CMAX : ce_cnt_q + CW'(1));
    oe_cnt_d = (oe_n || oe_hv) ? '0
             : ((oe_cnt_q == CMAX) ? CMAX : oe_cnt_q + CW'(1));
    id_ok    = (mode == MD_IDENT) && (addr[AW-1:1] == '0);
    src_ok   = (mode == MD_READ) || id_ok;
    on_d     = src_ok && !busy && (ce_cnt_d >= CW'(ACC_CYC)) && (oe_cnt_d >= CW'(OE_CYC));
    val_d    = id_ok ? (addr[0] ? DEV_CODE : MFR_CODE) : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_cnt_q <= '0;
      oe_cnt_q <= '0;
      addr_q   <= '0;
      hold_q   <= '0;
      en_q     <= 1'b0;
      dout_q   <= '0;
    end else begin
      ce_cnt_q <= ce_cnt_d;
      oe_cnt_q <= oe_cnt_d;
      addr_q   <= addr;
      en_q     <= on_d ? 1'b1 : (hold_q != '0);
      hold_q   <= on_d ? CW'(HZ_CYC) : ((hold_q != '0) ? hold_q - CW'(1) : '0);
      if (on_d) dout_q <= val_d;
    end
  end

  assign dout    = dout_q;
  assign dout_en = en_q & ~busy;

  // R2
  drive_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (!$past(ce_n) && !$past(oe_n)));

  // R3
  release_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($past(hold_q) == '0));

endmodule

// File: rtl/mtp_byte_mem.sv
module mtp_byte_mem
  import mtp_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CLK_MHZ     = 50,
  parameter int T_ACC_NS    = 70,
  parameter int T_OE_NS     = 35,
  parameter int T_HZ_NS     = 25,
  parameter int T_PROG_NS   = 15000,
  parameter int T_ERASE_NS  = 100000000,
  parameter int DEV_SEL     = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          oe_hv,
  input  logic          a9_hv,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          busy,
  output logic          err
);

  localparam int         ACC_CYC   = ns_to_cyc(T_ACC_NS, CLK_MHZ);
  localparam int         OE_CYC    = ns_to_cyc(T_OE_NS, CLK_MHZ);
  localparam int         HZ_CYC    = ns_to_cyc(T_HZ_NS, CLK_MHZ);
  localparam int         PROG_CYC  = ns_to_cyc(T_PROG_NS, CLK_MHZ);
  localparam int         ERASE_CYC = ns_to_cyc(T_ERASE_NS, CLK_MHZ);
  localparam logic [7:0] DEV_CODE  = dev_code(DEV_SEL);

  mtp_mode_t     mode;
  logic          prog_we, erase_we;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata, arr_rdata;

  mtp_mode_dec u_dec (
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .oe_hv (oe_hv),
    .a9_hv (a9_hv),
    .mode  (mode)
  );

  mtp_pulse_ctl #(
    .AW        (AW),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .addr     (addr),
    .din      (din),
    .busy     (busy),
    .err      (err),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .waddr    (waddr),
    .wdata    (wdata)
  );

  mtp_array #(.AW(AW)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .waddr    (waddr),
    .wdata    (wdata),
    .raddr    (addr),
    .rdata    (arr_rdata)
  );

  mtp_read_path #(
    .AW       (AW),
    .ACC_CYC  (ACC_CYC),
    .OE_CYC   (OE_CYC),
    .HZ_CYC   (HZ_CYC),
    .DEV_CODE (DEV_CODE)
  ) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .busy      (busy),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .oe_hv     (oe_hv),
    .addr      (addr),
    .arr_rdata (arr_rdata),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  // R11
  quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);

endmodule

// File: tb/tb_mtp_byte_mem.sv
module tb_mtp_byte_mem;

  localparam int ACC = 4;    // 70 ns at 50 MHz, rounded up
  localparam int OEC = 2;    // 35 ns
  localparam int HZC = 2;    // 25 ns
  localparam int PRG = 20;   // 400 ns
  localparam int ERS = 100;  // 2000 ns

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
  logic [7:0] addr = '0, din = '0;
  logic [7:0] dout;
  logic       dout_en, busy, err;

  always #10 clk = ~clk;

  mtp_byte_mem #(
    .AW(8), .CLK_MHZ(50), .T_ACC_NS(70), .T_OE_NS(35), .T_HZ_NS(25),
    .T_PROG_NS(400), .T_ERASE_NS(2000), .DEV_SEL(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .busy(busy), .err(err)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model, kept as plain behaviour
  int m_mem [256];
  int m_cnt, m_pa, m_pd, m_prev, m_cec, m_oec, m_hold, m_dout;
  bit m_busy, m_err, m_kind, m_wep, m_en;

  // 0 standby 1 read 2 off 3 erase 4 prog 5 inhibit 6 ident
  function automatic int mode_of();
    if (ce_n) return 0;
    if (oe_hv && a9_hv) return 3;
    if (oe_hv) return 4;
    if (oe_n) return 2;
    if (!we_n) return 5;
    if (a9_hv) return 6;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_busy = 0; m_err = 0; m_kind = 0; m_wep = 1; m_en = 0;
      m_cnt = 0; m_pa = 0; m_pd = 0; m_prev = 0; m_cec = 0; m_oec = 0;
      m_hold = 0; m_dout = 0;
    end else begin
      int  md, nce, noe, need;
      bit  ob, rdok, on, ok;
      md  = mode_of();
      ob  = m_busy;
      nce = (ce_n || addr != m_prev) ? 0 : m_cec + 1;
      noe = (oe_n || oe_hv) ? 0 : m_oec + 1;
      rdok = (md == 1) || (md == 6 && addr < 2);
      on  = rdok && !ob && nce >= ACC && noe >= OEC;
      if (on) m_dout = (md == 6) ? (addr[0] ? 8'hC2 : 8'hBF) : m_mem[addr];
      m_en   = on ? 1'b1 : (m_hold != 0);
      m_hold = on ? HZC : (m_hold > 0 ? m_hold - 1 : 0);
      m_cec = nce > 255 ? 255 : nce;
      m_oec = noe > 255 ? 255 : noe;
      m_prev = addr;
      if (ob) begin
        ok = m_kind ? (md == 3) : (md == 4);
        need = m_kind ? ERS : PRG;
        if (!ok) begin
          m_busy = 0; m_err = 1;
        end else if (we_n) begin
          m_busy = 0;
          if (m_cnt >= need) begin
            if (m_kind) foreach (m_mem[i]) m_mem[i] = 8'hFF;
            else m_mem[m_pa] = m_mem[m_pa] & m_pd;
          end else m_err = 1;
        end else m_cnt++;
      end else if (m_wep && !we_n && (md == 3 || md == 4)) begin
        m_busy = 1; m_err = 0; m_kind = (md == 3); m_cnt = 1;
        m_pa = addr; m_pd = din;
      end
      m_wep = we_n;
    end
  end

  // compare against the model on every falling edge, plus watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(cur_req, dout_en, (m_en && !m_busy) ? 1 : 0);
      if (dout_en && m_en && !m_busy) chk(cur_req, dout, m_dout);
      chk(cur_req, busy, m_busy);
      chk(cur_req, err, m_err);
    end
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 1; oe_hv = 0; a9_hv = 0;
  endtask

  task automatic read_at(input string req, input int a, input int exp);
    @(negedge clk);
    cur_req = req;
    addr = a[7:0]; ce_n = 0; oe_n = 0; we_n = 1; oe_hv = 0; a9_hv = 0;
    wait_cyc(ACC + 3);
    chk(req, dout_en, 1);
    chk(req, dout, exp);
  endtask

  task automatic pulse(input string req, input bit erase, input int a, input int d, input int low);
    @(negedge clk);
    cur_req = req;
    we_n = 1; ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = erase; addr = a[7:0]; din = d[7:0];
    wait_cyc(2);
    we_n = 0;
    wait_cyc(low);
    we_n = 1;
    wait_cyc(2);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    // R1: reset state
    chk("R1", dout_en, 0); chk("R1", busy, 0); chk("R1", err, 0);
    read_at("R1", 8'h05, 8'hFF);
    // R2: address change while selected
    read_at("R2", 8'h09, 8'hFF);
    read_at("R2", 8'hFE, 8'hFF);

    // R6: program and AND behaviour
    pulse("R6", 0, 8'h09, 8'h5A, PRG + 5);
    chk("R6", err, 0);
    read_at("R6", 8'h09, 8'h5A);
    pulse("R6", 0, 8'h09, 8'hF0, PRG);
    read_at("R6", 8'h09, 8'h50);
    pulse("R6", 0, 8'h00, 8'h12, PRG + 1);
    pulse("R6", 0, 8'hFF, 8'h81, PRG + 2);
    read_at("R6", 8'h00, 8'h12);
    read_at("R6", 8'hFF, 8'h81);

    // R8: one cycle short
    pulse("R8", 0, 8'h20, 8'h00, PRG - 1);
    chk("R8", err, 1);
    read_at("R8", 8'h20, 8'hFF);

    // R12: a new pulse clears the error
    pulse("R12", 0, 8'h21, 8'h77, PRG);
    chk("R12", err, 0);
    read_at("R12", 8'h21, 8'h77);

    // R9: program aborted by chip enable rising
    @(negedge clk);
    cur_req = "R9";
    ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = 0; addr = 8'h22; din = 8'h00; we_n = 1;
    wait_cyc(2); we_n = 0; wait_cyc(10);
    ce_n = 1;
    wait_cyc(2);
    chk("R9", err, 1); chk("R9", busy, 0);
    we_n = 1;
    read_at("R9", 8'h22, 8'hFF);
    // R9: erase aborted by a9 flag dropping
    @(negedge clk);
    ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = 1; we_n = 1;
    wait_cyc(2); we_n = 0; wait_cyc(30);
    a9_hv = 0;
    wait_cyc(2);
    chk("R9", err, 1); chk("R9", busy, 0);
    we_n = 1;
    read_at("R9", 8'h09, 8'h50);

    // R4: standby ignores strobes
    @(negedge clk);
    cur_req = "R4";
    ce_n = 1; oe_n = 0; oe_hv = 0; a9_hv = 0; addr = 8'h09; din = 8'h00;
    wait_cyc(HZC + 2);
    chk("R4", dout_en, 0);
    oe_hv = 1; oe_n = 1;
    wait_cyc(2); we_n = 0; wait_cyc(PRG + 5);
    chk("R4", busy, 0);
    we_n = 1;
    read_at("R4", 8'h09, 8'h50);

    // R5: output-off and inhibit
    @(negedge clk);
    cur_req = "R5";
    oe_n = 1;
    wait_cyc(HZC + 2);
    chk("R5", dout_en, 0);
    read_at("R5", 8'h09, 8'h50);
    @(negedge clk);
    we_n = 0;
    wait_cyc(HZC + 2);
    chk("R5", dout_en, 0);
    chk("R5", busy, 0);
    we_n = 1;

    // R3: turn-off window
    read_at("R3", 8'h21, 8'h77);
    @(negedge clk);
    oe_n = 1;
    wait_cyc(HZC);
    chk("R3", dout_en, 1);
    chk("R3", dout, 8'h77);
    wait_cyc(1);
    chk("R3", dout_en, 0);

    // R10: identification codes
    @(negedge clk);
    cur_req = "R10";
    ce_n = 0; oe_n = 0; we_n = 1; oe_hv = 0; a9_hv = 1; addr = 8'h00;
    wait_cyc(ACC + 3);
    chk("R10", dout_en, 1); chk("R10", dout, 8'hBF);
    addr = 8'h01;
    wait_cyc(ACC + 3);
    chk("R10", dout_en, 1); chk("R10", dout, 8'hC2);
    addr = 8'h02;
    wait_cyc(HZC + 3);
    chk("R10", dout_en, 0);
    go_idle();

    // R11: a pulse starting inside the hold window silences the bus
    read_at("R11", 8'h09, 8'h50);
    @(negedge clk);
    cur_req = "R11";
    oe_n = 1; oe_hv = 1; din = 8'hFF; we_n = 0;
    wait_cyc(1);
    chk("R11", busy, 1);
    chk("R11", dout_en, 0);
    wait_cyc(PRG + 2);
    we_n = 1;
    wait_cyc(2);
    read_at("R11", 8'h09, 8'h50);

    // R7: whole-array erase, exactly the minimum
    pulse("R7", 1, 8'h00, 8'h00, ERS);
    chk("R7", err, 0);
    read_at("R7", 8'h09, 8'hFF);
    read_at("R7", 8'h00, 8'hFF);
    read_at("R7", 8'hFF, 8'hFF);
    read_at("R7", 8'h21, 8'hFF);

    go_idle();
    wait_cyc(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule